// File: doc/BRIEF.md
# Coprocessor Transfer Handshake Sequencer

This block sits in a processor core and runs the handshake between the core and an external coprocessor. It handles four instruction classes: coprocessor memory load, coprocessor memory store, register moves in either direction, and internal coprocessor data operations. A one-cycle `start` pulse launches an operation. The block then presents a sequence of phase codes to the coprocessor. For each phase that asks for an answer, the coprocessor returns a two-bit status. At the end the block pulses `done`, together with either an undefined-instruction flag or an abort flag, or with neither.

For loads and stores the sequencer also issues memory requests. Addresses are post-indexed: the first word goes to the supplied base address, and every time the coprocessor answers "increment" the next word goes 4 bytes higher. Data words travel on paths outside this block. Writing back the base register and decoding instructions are left to neighbouring logic.

Top module: `cpx_seq`

## Requirements
- R1: In the cycle after reset is released, every output is low.
- R2: If `start` arrives while the permission bit `cp_allow[cp_num]` is clear, `done` and `undef` pulse in the next cycle and no phase is ever shown.
- R3: An accepted `start` shows phase FIRST (code 0) in the next cycle. A status of busy (01) is followed by one cycle with `idle_cyc` high. Then, if no interrupt is pending, phase BUSY (code 1) is shown and the block waits for a fresh answer.
- R4: If `irq_pend` is high during the idle cycle of a busy wait, the next cycle shows phase INTR (code 2). The cycle after that pulses `done` with no error flag, and no memory request is ever made.
- R5: A can't status (10) on FIRST or BUSY ends the operation without a memory request. For load (op 0) and store (op 1) it raises `abort`; for the other ops it raises `undef`.
- R6: For a load or store, a done (00) or increment (11) status on the handshake leads to one phase XFER (code 3). Then come DATA phases (code 4), one memory request each. The first request goes to the base address, and each increment answer adds 4 for the next word. Any other answer ends the transfer. `mem_we` is high only for a store.
- R7: Bits 1:0 of `mem_addr` are zero on every request.
- R8: A store whose base address is an address exception (any bit at or above `LEGAL_W` set) or lies in the vector area (below `VEC_TOP`) still moves its data, then ends with `abort`. A load ends with `abort` only for an address exception.
- R9: If `mem_abort` is high during any DATA phase, the load or store ends with `abort`.
- R10: A move to the coprocessor (op 2) gives one `cp_cyc` cycle and then `done`. A move from the coprocessor (op 3) gives `cp_cyc`, then one `idle_cyc`, then `done`. A data operation (op 4) pulses `done` right after the handshake.
- R11: A `start` that arrives while an operation is in progress has no effect on the phase, memory and completion outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled while idle |
| op | input | 3 | Operation: 0 load, 1 store, 2 move to coprocessor, 3 move from coprocessor, 4 data op |
| cp_num | input | CPW | Selected coprocessor number |
| cp_allow | input | 2**CPW | Per-coprocessor access permission bits |
| base_addr | input | AW | Start address for load/store |
| irq_pend | input | 1 | Interrupt pending |
| cp_status | input | 2 | Coprocessor answer: 00 done, 01 busy, 10 can't, 11 increment |
| mem_abort | input | 1 | Memory abort for the current data phase |
| phase_valid | output | 1 | A phase is being presented |
| phase | output | 3 | Phase code |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned request address |
| idle_cyc | output | 1 | Idle-cycle strobe |
| cp_cyc | output | 1 | Coprocessor-cycle strobe |
| done | output | 1 | Operation finished |
| undef | output | 1 | Undefined-instruction indication, with done |
| abort | output | 1 | Abort indication, with done |

## Verification
The assertions assume that `start` is a single-cycle pulse and that the coprocessor's status is stable at each clock edge. They also assume that a transfer does not run long enough for its address to wrap around. The stimulus drives every input on the falling edge. A responder answers each FIRST, BUSY and DATA phase with the next entry of a scripted list, and any answers beyond the script read as done. Base addresses are chosen low enough that a multi-word burst never wraps.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_STORE   = 3'd1,
        OP_TO_CP   = 3'd2,
        OP_FROM_CP = 3'd3,
        OP_DATA    = 3'd4
    } cpx_op_e;

    typedef enum logic [1:0] {
        ST_DONE = 2'b00,
        ST_BUSY = 2'b01,
        ST_CANT = 2'b10,
        ST_INC  = 2'b11
    } cpx_stat_e;

    typedef enum logic [2:0] {
        PH_FIRST = 3'd0,
        PH_BUSY  = 3'd1,
        PH_INTR  = 3'd2,
        PH_XFER  = 3'd3,
        PH_DATA  = 3'd4
    } cpx_phase_e;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_UNDEF = 2'd1,
        RES_ABORT = 2'd2
    } cpx_res_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FIRST,
        S_WAIT,
        S_BUSY,
        S_INTR,
        S_XFER,
        S_DATA,
        S_CPCYC,
        S_TAIL,
        S_END
    } cpx_state_e;

    typedef struct packed {
        logic       valid;
        cpx_phase_e code;
    } cpx_phase_t;

    function automatic logic op_is_mem(cpx_op_e o);
        return (o == OP_LOAD) || (o == OP_STORE);
    endfunction

    function automatic logic op_is_move(cpx_op_e o);
        return (o == OP_TO_CP) || (o == OP_FROM_CP);
    endfunction

    function automatic cpx_res_e refusal_result(cpx_op_e o);
        return op_is_mem(o) ? RES_ABORT : RES_UNDEF;
    endfunction

endpackage

// File: rtl/cpx_gate.sv
module cpx_gate
    import cpx_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CPW     = 4,
    parameter int LEGAL_W = 26,
    parameter int VEC_TOP = 32
) (
    input  logic [(1<<CPW)-1:0] cp_allow,
    input  logic [CPW-1:0]      cp_num,
    input  logic [2:0]          op,
    input  logic [AW-1:0]       base_addr,
    output logic                allowed,
    output logic                early_fault
);
    localparam logic [AW-1:0] VEC_LIMIT = AW'(VEC_TOP);

    logic addr_exc;
    logic in_vec;
    cpx_op_e op_e;

    assign op_e    = cpx_op_e'(op);
    assign allowed = cp_allow[cp_num];

    generate
        if (LEGAL_W < AW) begin : g_exc
            assign addr_exc = |base_addr[AW-1:LEGAL_W];
        end else begin : g_noexc
            assign addr_exc = 1'b0;
        end
    endgenerate

    assign in_vec = (base_addr < VEC_LIMIT);

    always_comb begin
        case (op_e)
            OP_STORE: early_fault = addr_exc | in_vec;
            OP_LOAD:  early_fault = addr_exc;
            default:  early_fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpx_addr.sv
module cpx_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base_addr,
    output logic [AW-1:0] word_addr
);
    localparam logic [AW-1:0] STRIDE = AW'(4);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load)
            addr_q <= base_addr;
        else if (step)
            addr_q <= addr_q + STRIDE;
    end

    assign word_addr = {addr_q[AW-1:2], 2'b00};
endmodule

// File: rtl/cpx_ctl.sv
module cpx_ctl
    import cpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] op,
    input  logic       allowed,
    input  logic       early_fault,
    input  logic       irq_pend,
    input  logic [1:0] cp_status,
    input  logic       mem_abort,
    output logic       phase_valid,
    output logic [2:0] phase,
    output logic       mem_req,
    output logic       mem_we,
    output logic       idle_cyc,
    output logic       cp_cyc,
    output logic       done,
    output logic       undef,
    output logic       abort,
    output logic       addr_load,
    output logic       addr_step
);
    cpx_state_e state_q, state_n;
    cpx_res_e   res_q, res_n;
    cpx_op_e    op_q;
    logic       fault_q;
    cpx_stat_e  stat;
    cpx_phase_t ph;

    assign stat = cpx_stat_e'(cp_status);

    always_comb begin
        state_n   = state_q;
        res_n     = res_q;
        addr_load = 1'b0;
        addr_step = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (start) begin
                    addr_load = 1'b1;
                    if (!allowed) begin
                        state_n = S_END;
                        res_n   = RES_UNDEF;
                    end else begin
                        state_n = S_FIRST;
                        res_n   = RES_OK;
                    end
                end
            end
            S_FIRST, S_BUSY: begin
                case (stat)
                    ST_BUSY: state_n = S_WAIT;
                    ST_CANT: begin
                        state_n = S_END;
                        res_n   = refusal_result(op_q);
                    end
                    default: begin
                        if (op_is_mem(op_q))
                            state_n = S_XFER;
                        else if (op_is_move(op_q))
                            state_n = S_CPCYC;
                        else begin
                            state_n = S_END;
                            res_n   = RES_OK;
                        end
                    end
                endcase
            end
            S_WAIT:  state_n = irq_pend ? S_INTR : S_BUSY;
            S_INTR: begin
                state_n = S_END;
                res_n   = RES_OK;
            end
            S_XFER:  state_n = S_DATA;
            S_DATA: begin
                if (stat == ST_INC) begin
                    addr_step = 1'b1;
                end else begin
                    state_n = S_END;
                    res_n   = (fault_q | mem_abort) ? RES_ABORT : RES_OK;
                end
            end
            S_CPCYC: begin
                if (op_q == OP_FROM_CP)
                    state_n = S_TAIL;
                else begin
                    state_n = S_END;
                    res_n   = RES_OK;
                end
            end
            S_TAIL: begin
                state_n = S_END;
                res_n   = RES_OK;
            end
            S_END:   state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            res_q   <= RES_OK;
            op_q    <= OP_DATA;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_n;
            res_q   <= res_n;
            if (state_q == S_IDLE && start) begin
                op_q    <= cpx_op_e'(op);
                fault_q <= early_fault;
            end else if (state_q == S_DATA && mem_abort) begin
                fault_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ph = '{valid: 1'b0, code: PH_FIRST};
        case (state_q)
            S_FIRST: ph = '{valid: 1'b1, code: PH_FIRST};
            S_BUSY:  ph = '{valid: 1'b1, code: PH_BUSY};
            S_INTR:  ph = '{valid: 1'b1, code: PH_INTR};
            S_XFER:  ph = '{valid: 1'b1, code: PH_XFER};
            S_DATA:  ph = '{valid: 1'b1, code: PH_DATA};
            default: ph = '{valid: 1'b0, code: PH_FIRST};
        endcase
    end

    assign phase_valid = ph.valid;
    assign phase       = ph.code;
    assign mem_req     = (state_q == S_DATA);
    assign mem_we      = (state_q == S_DATA) && (op_q == OP_STORE);
    assign idle_cyc    = (state_q == S_WAIT) || (state_q == S_TAIL);
    assign cp_cyc      = (state_q == S_CPCYC);
    assign done        = (state_q == S_END);
    assign undef       = (state_q == S_END) && (res_q == RES_UNDEF);
    assign abort       = (state_q == S_END) && (res_q == RES_ABORT);
endmodule

// File: rtl/cpx_seq.sv
module cpx_seq
    import cpx_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CPW     = 4,
    parameter int LEGAL_W = 26,
    parameter int VEC_TOP = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2:0]          op,
    input  logic [CPW-1:0]      cp_num,
    input  logic [(1<<CPW)-1:0] cp_allow,
    input  logic [AW-1:0]       base_addr,
    input  logic                irq_pend,
    input  logic [1:0]          cp_status,
    input  logic                mem_abort,
    output logic                phase_valid,
    output logic [2:0]          phase,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic                idle_cyc,
    output logic                cp_cyc,
    output logic                done,
    output logic                undef,
    output logic                abort
);
    logic allowed;
    logic early_fault;
    logic addr_load;
    logic addr_step;

    cpx_gate #(
        .AW(AW), .CPW(CPW), .LEGAL_W(LEGAL_W), .VEC_TOP(VEC_TOP)
    ) u_gate (
        .cp_allow    (cp_allow),
        .cp_num      (cp_num),
        .op          (op),
        .base_addr   (base_addr),
        .allowed     (allowed),
        .early_fault (early_fault)
    );

    cpx_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .op          (op),
        .allowed     (allowed),
        .early_fault (early_fault),
        .irq_pend    (irq_pend),
        .cp_status   (cp_status),
        .mem_abort   (mem_abort),
        .phase_valid (phase_valid),
        .phase       (phase),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .idle_cyc    (idle_cyc),
        .cp_cyc      (cp_cyc),
        .done        (done),
        .undef       (undef),
        .abort       (abort),
        .addr_load   (addr_load),
        .addr_step   (addr_step)
    );

    cpx_addr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (addr_load),
        .step      (addr_step),
        .base_addr (base_addr),
        .word_addr (mem_addr)
    );
endmodule

// File: rtl/cpx_seq_chk.sv
module cpx_seq_chk #(
    parameter int AW  = 32,
    parameter int CPW = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [CPW-1:0]      cp_num,
    input logic [(1<<CPW)-1:0] cp_allow,
    input logic                phase_valid,
    input logic [2:0]          phase,
    input logic                mem_req,
    input logic [AW-1:0]       mem_addr,
    input logic                idle_cyc,
    input logic                done,
    input logic                undef,
    input logic                abort
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= 1'b0;
        else if (!active_q && start)
            active_q <= 1'b1;
        else if (done)
            active_q <= 1'b0;
    end

    // R2
    a_r2_denied_undef: assert property (@(posedge clk) disable iff (rst)
        (!active_q && start && !cp_allow[cp_num]) |=> (done && undef && !phase_valid));

    // R3
    a_r3_busy_after_idle: assert property (@(posedge clk) disable iff (rst)
        (phase_valid && phase == 3'd1) |-> $past(idle_cyc));

    // R4
    a_r4_intr_clean_end: assert property (@(posedge clk) disable iff (rst)
        (phase_valid && phase == 3'd2) |=> (done && !undef && !abort));

    // R5
    a_r5_one_flag: assert property (@(posedge clk) disable iff (rst)
        !(undef && abort));

    // R6
    a_r6_word_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + AW'(4)));

    // R7
    a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R10
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!phase_valid && !mem_req));
endmodule

bind cpx_seq cpx_seq_chk #(.AW(AW), .CPW(CPW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cp_num      (cp_num),
    .cp_allow    (cp_allow),
    .phase_valid (phase_valid),
    .phase       (phase),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .idle_cyc    (idle_cyc),
    .done        (done),
    .undef       (undef),
    .abort       (abort)
);

// File: tb/sim_cpx_seq.sv
`timescale 1ns/1ps
module sim_cpx_seq;
    localparam int AW = 32;
    localparam int CPW = 4;

    typedef struct packed {
        logic          pv;
        logic [2:0]    ph;
        logic          mr;
        logic          mw;
        logic [AW-1:0] ma;
        logic          ic;
        logic          cc;
        logic          dn;
        logic          ud;
        logic          ab;
    } ev_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] op = 3'd4;
    logic [CPW-1:0] cp_num = '0;
    logic [(1<<CPW)-1:0] cp_allow = 16'hFFDF;
    logic [AW-1:0] base_addr = '0;
    logic irq_pend = 1'b0;
    logic [1:0] cp_status = 2'b00;
    logic mem_abort = 1'b0;
    logic phase_valid, mem_req, mem_we, idle_cyc, cp_cyc, done, undef, abort;
    logic [2:0] phase;
    logic [AW-1:0] mem_addr;

    always #4 clk = ~clk;

    cpx_seq u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .cp_num(cp_num),
        .cp_allow(cp_allow), .base_addr(base_addr), .irq_pend(irq_pend),
        .cp_status(cp_status), .mem_abort(mem_abort),
        .phase_valid(phase_valid), .phase(phase), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .idle_cyc(idle_cyc),
        .cp_cyc(cp_cyc), .done(done), .undef(undef), .abort(abort)
    );

    int checks = 0;
    int fails = 0;
    int dones = 0;
    bit finished = 0;
    string cur_req = "R1";

    ev_t exp_q[$];
    logic [1:0] rsp[16];
    int nrsp = 0;
    int rsp_i = 0;
    logic mab[16];
    int nmab = 0;
    int mab_i = 0;
    bit monitor_on = 0;

    function automatic ev_t mk(logic pv, logic [2:0] ph, logic mr, logic mw,
                               logic [AW-1:0] ma, logic ic, logic cc,
                               logic dn, logic ud, logic ab);
        ev_t e;
        e.pv = pv; e.ph = pv ? ph : 3'd0; e.mr = mr; e.mw = mr ? mw : 1'b0;
        e.ma = mr ? ma : '0; e.ic = ic; e.cc = cc; e.dn = dn; e.ud = ud; e.ab = ab;
        return e;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Responder: answers FIRST, BUSY and DATA phases from the script.
    always @(negedge clk) begin
        if (phase_valid && (phase == 3'd0 || phase == 3'd1 || phase == 3'd4)) begin
            cp_status = (rsp_i < nrsp) ? rsp[rsp_i] : 2'b00;
            rsp_i++;
        end else begin
            cp_status = 2'b00;
        end
        if (mem_req) begin
            mem_abort = (mab_i < nmab) ? mab[mab_i] : 1'b0;
            mab_i++;
        end else begin
            mem_abort = 1'b0;
        end
    end

    // Monitor: compares each non-quiet cycle with the next expected item.
    always @(negedge clk) begin
        if (monitor_on && (phase_valid || mem_req || idle_cyc || cp_cyc || done || undef || abort)) begin
            ev_t act;
            act = mk(phase_valid, phase, mem_req, mem_we, mem_addr, idle_cyc, cp_cyc, done, undef, abort);
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected activity %h, expected nothing", cur_req, act);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", cur_req, act, e);
                end
            end
            if (done) dones++;
        end
    end

    // Builds the expected sequence from the scripts and the requirements.
    task automatic model(logic [2:0] o, bit allow, logic [AW-1:0] base, bit irq);
        int ri = 0;
        int ai = 0;
        bit is_mem = (o == 3'd0) || (o == 3'd1);
        logic [1:0] r;
        logic [AW-1:0] a;
        bit ab;
        if (!allow) begin
            exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1, 1, 0));
            return;
        end
        exp_q.push_back(mk(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0));
        forever begin
            r = (ri < nrsp) ? rsp[ri] : 2'b00;
            ri++;
            if (r == 2'b01) begin
                exp_q.push_back(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 0));
                if (irq) begin
                    exp_q.push_back(mk(1, 3'd2, 0, 0, 0, 0, 0, 0, 0, 0));
                    exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0));
                    return;
                end
                exp_q.push_back(mk(1, 3'd1, 0, 0, 0, 0, 0, 0, 0, 0));
            end else if (r == 2'b10) begin
                exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1, !is_mem, is_mem));
                return;
            end else begin
                break;
            end
        end
        if (is_mem) begin
            ab = (base[31:26] != 0) || ((o == 3'd1) && (base < 32));
            a = {base[AW-1:2], 2'b00};
            exp_q.push_back(mk(1, 3'd3, 0, 0, 0, 0, 0, 0, 0, 0));
            forever begin
                r = (ri < nrsp) ? rsp[ri] : 2'b00;
                ri++;
                exp_q.push_back(mk(1, 3'd4, 1, (o == 3'd1), a, 0, 0, 0, 0, 0));
                if (ai < nmab && mab[ai]) ab = 1;
                ai++;
                if (r == 2'b11) a = a + 4;
                else break;
            end
            exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1, 0, ab));
        end else if (o == 3'd2) begin
            exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
            exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        end else if (o == 3'd3) begin
            exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
            exp_q.push_back(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 0));
            exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        end else begin
            exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        end
    endtask

    // Driver: pushes the expectation, launches the op, waits for completion.
    task automatic run_op(string req, logic [2:0] o, logic [CPW-1:0] cp,
                          logic [AW-1:0] base, bit irq, bit poke);
        int prev;
        cur_req = req;
        rsp_i = 0;
        mab_i = 0;
        model(o, cp_allow[cp], base, irq);
        prev = dones;
        @(negedge clk);
        op = o; cp_num = cp; base_addr = base; irq_pend = irq; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            op = 3'd0; cp_num = 4'd1; base_addr = 32'h40; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (dones == prev) @(negedge clk);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected items left, expected 0", req, exp_q.size());
            exp_q.delete();
        end
        irq_pend = 1'b0;
        nrsp = 0;
        nmab = 0;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        checks++;
        if ({phase_valid, mem_req, mem_we, idle_cyc, cp_cyc, done, undef, abort} !== 8'b0 || mem_addr !== '0) begin
            fails++;
            $display("FAIL R1: outputs %b addr %h, expected all zero",
                     {phase_valid, mem_req, mem_we, idle_cyc, cp_cyc, done, undef, abort}, mem_addr);
        end
        monitor_on = 1;

        // R2: coprocessor 5 is denied
        run_op("R2", 3'd2, 4'd5, 32'h100, 0, 0);

        // R3: two busy answers, then done, on a data op (R10 data op)
        rsp[0] = 2'b01; rsp[1] = 2'b01; rsp[2] = 2'b00; nrsp = 3;
        run_op("R3", 3'd4, 4'd2, 32'h0, 0, 0);

        // R4: interrupt during busy wait of a load
        rsp[0] = 2'b01; nrsp = 1;
        run_op("R4", 3'd0, 4'd1, 32'h100, 1, 0);

        // R5: can't on a move gives undef, on a load after busy gives abort
        rsp[0] = 2'b10; nrsp = 1;
        run_op("R5", 3'd2, 4'd3, 32'h0, 0, 0);
        rsp[0] = 2'b01; rsp[1] = 2'b10; nrsp = 2;
        run_op("R5", 3'd0, 4'd3, 32'h100, 0, 0);

        // R6: three-word load
        rsp[0] = 2'b00; rsp[1] = 2'b11; rsp[2] = 2'b11; rsp[3] = 2'b00; nrsp = 4;
        run_op("R6", 3'd0, 4'd7, 32'h100, 0, 0);

        // R7: unaligned store base, two words
        rsp[0] = 2'b11; rsp[1] = 2'b11; rsp[2] = 2'b00; nrsp = 3;
        run_op("R7", 3'd1, 4'd7, 32'h203, 0, 0);

        // R8: store into vector area aborts, load there does not, load exception aborts
        rsp[0] = 2'b00; rsp[1] = 2'b11; rsp[2] = 2'b00; nrsp = 3;
        run_op("R8", 3'd1, 4'd0, 32'h10, 0, 0);
        rsp[0] = 2'b00; rsp[1] = 2'b00; nrsp = 2;
        run_op("R8", 3'd0, 4'd0, 32'h10, 0, 0);
        rsp[0] = 2'b00; rsp[1] = 2'b00; nrsp = 2;
        run_op("R8", 3'd0, 4'd0, 32'h0400_0100, 0, 0);
        rsp[0] = 2'b00; rsp[1] = 2'b00; nrsp = 2;
        run_op("R8", 3'd1, 4'd0, 32'h0800_0000, 0, 0);

        // R9: memory abort on the second of three words
        rsp[0] = 2'b00; rsp[1] = 2'b11; rsp[2] = 2'b11; rsp[3] = 2'b00; nrsp = 4;
        mab[0] = 1'b0; mab[1] = 1'b1; mab[2] = 1'b0; nmab = 3;
        run_op("R9", 3'd0, 4'd4, 32'h300, 0, 0);

        // R10: moves in both directions
        rsp[0] = 2'b00; nrsp = 1;
        run_op("R10", 3'd2, 4'd6, 32'h0, 0, 0);
        rsp[0] = 2'b01; rsp[1] = 2'b00; nrsp = 2;
        run_op("R10", 3'd3, 4'd6, 32'h0, 0, 0);

        // R11: second start during a busy wait is ignored
        rsp[0] = 2'b01; rsp[1] = 2'b01; rsp[2] = 2'b01; rsp[3] = 2'b00; nrsp = 4;
        run_op("R11", 3'd4, 4'd8, 32'h0, 0, 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule